// File: doc/BRIEF.md
# Ordered Store Buffer with Load Race Watch

This block sits between a core's commit stage and the memory system and keeps stores in total store order. A committed store is written into a first-in first-out buffer and counts as ordered only once it leaves the buffer and writes memory. Stores leave strictly in commit order, one per accepted memory write. A load looks up the buffer by address. If at least one buffered store matches, the youngest such store supplies the value. If none matches, the value supplied by memory on the load's data input is returned.

Each accepted load also takes a watch slot. The slot's window opens when the load's value becomes ordered. For a load served by memory, that is the load's own cycle. For a forwarded load, it is the cycle in which the forwarding store drains. The window closes when every store that was buffered at the time of the load has drained. An invalidation to the load's address that arrives while the window is open marks the load. When the window closes, the slot reports the load's tag, its value and the mark. A replay log keeps the values of marked loads and replays those loads by value, which breaks the ordering cycles that store buffering can create.

Top module: `store_order_buf`

## Requirements
- R1: Stores are presented on the memory write port in the order they were committed. While `mem_wr_valid_o` is high and `mem_wr_ready_i` is low, the presented address and data stay unchanged.
- R2: `st_ready_o` is low exactly when DEPTH stores are buffered. `idle_o` is high exactly when no store is buffered, and `mem_wr_valid_o` is its inverse.
- R3: A load whose address matches no buffered store returns `ld_mem_data_i` with `ld_fwd_o` low in the same cycle.
- R4: A load whose address matches one or more buffered stores returns the data of the most recently committed matching store, with `ld_fwd_o` high.
- R5: A store committed in the same cycle as a load is younger than that load and is not forwarded to it.
- R6: A load accepted while the buffer is empty has no window. It is reported in the next cycle with `rpt_log_o` low.
- R7: An invalidation to a load's address in any cycle after its window opened, up to and including the cycle of the closing drain, sets `rpt_log_o` for that load.
- R8: An invalidation to a different address, or one that arrives before the forwarding store has drained, leaves `rpt_log_o` low.
- R9: A load is reported, with its `ld_id_i` tag and its returned value, from the cycle after the drain that closes its window.
- R10: `ld_ready_o` is low while all SLOTS watch slots are occupied, and a load is accepted only when `ld_ready_o` is high.
- R11: When several slots are ready to report, one is reported per cycle, lowest slot index first. Slots are allocated lowest free index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_valid_i | input | 1 | Store commit request |
| st_ready_o | output | 1 | Buffer can take a store |
| st_addr_i | input | AW | Store address |
| st_data_i | input | DW | Store data |
| mem_wr_valid_o | output | 1 | Oldest store presented to memory |
| mem_wr_ready_i | input | 1 | Memory accepts the presented store |
| mem_wr_addr_o | output | AW | Address of oldest store |
| mem_wr_data_o | output | DW | Data of oldest store |
| ld_valid_i | input | 1 | Load request |
| ld_ready_o | output | 1 | A watch slot is free |
| ld_addr_i | input | AW | Load address |
| ld_id_i | input | IDW | Load tag carried to the report |
| ld_mem_data_i | input | DW | Memory value for the load address |
| ld_data_o | output | DW | Load result, same cycle |
| ld_fwd_o | output | 1 | Result came from the buffer |
| inv_valid_i | input | 1 | Invalidation arrives |
| inv_addr_i | input | AW | Invalidated address |
| rpt_valid_o | output | 1 | A closed load is reported |
| rpt_id_o | output | IDW | Tag of reported load |
| rpt_data_o | output | DW | Value of reported load |
| rpt_log_o | output | 1 | Value must be logged for replay |
| idle_o | output | 1 | Buffer empty |

## Verification
The assertions check the buffer-level invariants on every cycle: the memory write port holds steady under back-pressure, full and idle agree with the write port, loads against an empty buffer never forward, and a load against an empty buffer is followed by a report. Forwarding from the youngest of several matches, the exact edges of the watch window (an invalidation before the forwarding store drains, in the closing cycle, or to another address), the commit order of drained stores and the report order across slots depend on sequences of stores, drains and invalidations. Only the bench's directed scenarios can show those.

// File: rtl/sob_pkg.sv
package sob_pkg;
  typedef enum logic [1:0] {W_FREE, W_WAIT, W_OPEN, W_DONE} win_e;
endpackage

// File: rtl/sob_fifo.sv
module sob_fifo #(
  parameter int DEPTH = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int SW = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  input  logic [AW-1:0] lk_addr_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic [SW-1:0] head_seq_o,
  output logic [SW-1:0] tail_seq_o,
  output logic          lk_hit_o,
  output logic [DW-1:0] lk_data_o,
  output logic [SW-1:0] lk_seq_o
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [SW-1:0] wr_q, rd_q, cnt;
  logic [SW-1:0] ent_seq [DEPTH];
  logic [DEPTH-1:0] ent_match;

  assign cnt         = wr_q - rd_q;
  assign full_o      = (cnt == SW'(DEPTH));
  assign empty_o     = (cnt == '0);
  assign head_addr_o = addr_q[rd_q[PW-1:0]];
  assign head_data_o = data_q[rd_q[PW-1:0]];
  assign head_seq_o  = rd_q;
  assign tail_seq_o  = wr_q - SW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_q + SW'(1);
      if (pop_i)  rd_q <= rd_q + SW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_q[PW-1:0]] <= push_addr_i;
      data_q[wr_q[PW-1:0]] <= push_data_i;
    end
  end

  // age-ordered view: index 0 is oldest
  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    assign ent_seq[g]   = rd_q + SW'(g);
    assign ent_match[g] = (SW'(g) < cnt) && (addr_q[ent_seq[g][PW-1:0]] == lk_addr_i);
  end

  // later (younger) matches override older ones
  always_comb begin
    lk_hit_o  = 1'b0;
    lk_data_o = '0;
    lk_seq_o  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_match[i]) begin
        lk_hit_o  = 1'b1;
        lk_data_o = data_q[ent_seq[i][PW-1:0]];
        lk_seq_o  = ent_seq[i];
      end
    end
  end
endmodule

// File: rtl/sob_pick.sv
module sob_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_o = N'(1) << i;
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/sob_watch.sv
module sob_watch
  import sob_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IDW = 4,
  parameter int SW = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [SLOTS-1:0]          alloc_i,
  input  logic [AW-1:0]             cap_addr_i,
  input  logic [IDW-1:0]            cap_id_i,
  input  logic [DW-1:0]             cap_data_i,
  input  logic [SW-1:0]             cap_open_seq_i,
  input  logic [SW-1:0]             cap_close_seq_i,
  input  logic                      cap_open_i,
  input  logic                      cap_close_i,
  input  logic                      drain_i,
  input  logic [SW-1:0]             drain_seq_i,
  input  logic                      inv_valid_i,
  input  logic [AW-1:0]             inv_addr_i,
  input  logic [SLOTS-1:0]          release_i,
  output logic [SLOTS-1:0]          busy_o,
  output logic [SLOTS-1:0]          done_o,
  output logic [SLOTS-1:0][IDW-1:0] id_o,
  output logic [SLOTS-1:0][DW-1:0]  data_o,
  output logic [SLOTS-1:0]          log_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    win_e          st_q;
    logic [AW-1:0] addr_q;
    logic [SW-1:0] open_seq_q, close_seq_q;
    logic          flag_q;
    logic          drain_open, drain_close, inv_hit;

    assign drain_open  = drain_i && (drain_seq_i == open_seq_q);
    assign drain_close = drain_i && (drain_seq_i == close_seq_q);
    assign inv_hit     = inv_valid_i && (inv_addr_i == addr_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q        <= W_FREE;
        addr_q      <= '0;
        open_seq_q  <= '0;
        close_seq_q <= '0;
        flag_q      <= 1'b0;
        id_o[g]     <= '0;
        data_o[g]   <= '0;
      end else begin
        unique case (st_q)
          W_FREE: if (alloc_i[g]) begin
            addr_q      <= cap_addr_i;
            open_seq_q  <= cap_open_seq_i;
            close_seq_q <= cap_close_seq_i;
            id_o[g]     <= cap_id_i;
            data_o[g]   <= cap_data_i;
            flag_q      <= 1'b0;
            if (cap_close_i)     st_q <= W_DONE;
            else if (cap_open_i) st_q <= W_OPEN;
            else                 st_q <= W_WAIT;
          end
          W_WAIT: begin
            if (drain_close)     st_q <= W_DONE;
            else if (drain_open) st_q <= W_OPEN;
          end
          W_OPEN: begin
            if (inv_hit)     flag_q <= 1'b1;
            if (drain_close) st_q   <= W_DONE;
          end
          W_DONE: if (release_i[g]) st_q <= W_FREE;
          default: st_q <= W_FREE;
        endcase
      end
    end

    assign busy_o[g] = (st_q != W_FREE);
    assign done_o[g] = (st_q == W_DONE);
    assign log_o[g]  = flag_q;
  end
endmodule

// File: rtl/store_order_buf.sv
module store_order_buf #(
  parameter int DEPTH = 4,
  parameter int SLOTS = 4,
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IDW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           st_valid_i,
  output logic           st_ready_o,
  input  logic [AW-1:0]  st_addr_i,
  input  logic [DW-1:0]  st_data_i,
  output logic           mem_wr_valid_o,
  input  logic           mem_wr_ready_i,
  output logic [AW-1:0]  mem_wr_addr_o,
  output logic [DW-1:0]  mem_wr_data_o,
  input  logic           ld_valid_i,
  output logic           ld_ready_o,
  input  logic [AW-1:0]  ld_addr_i,
  input  logic [IDW-1:0] ld_id_i,
  input  logic [DW-1:0]  ld_mem_data_i,
  output logic [DW-1:0]  ld_data_o,
  output logic           ld_fwd_o,
  input  logic           inv_valid_i,
  input  logic [AW-1:0]  inv_addr_i,
  output logic           rpt_valid_o,
  output logic [IDW-1:0] rpt_id_o,
  output logic [DW-1:0]  rpt_data_o,
  output logic           rpt_log_o,
  output logic           idle_o
);
  localparam int SW = $clog2(DEPTH) + 1;

  logic          full, empty, push, drain, hit, ld_acc, cap_open, cap_close;
  logic [SW-1:0] head_seq, tail_seq, hit_seq;
  logic [DW-1:0] hit_data;
  logic [SLOTS-1:0] busy, done, free_gnt, rpt_gnt, alloc, slot_log;
  logic [SLOTS-1:0][IDW-1:0] slot_id;
  logic [SLOTS-1:0][DW-1:0]  slot_data;

  assign push  = st_valid_i && st_ready_o;
  assign drain = mem_wr_valid_o && mem_wr_ready_i;

  sob_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_addr_i (st_addr_i),
    .push_data_i (st_data_i),
    .pop_i       (drain),
    .lk_addr_i   (ld_addr_i),
    .full_o      (full),
    .empty_o     (empty),
    .head_addr_o (mem_wr_addr_o),
    .head_data_o (mem_wr_data_o),
    .head_seq_o  (head_seq),
    .tail_seq_o  (tail_seq),
    .lk_hit_o    (hit),
    .lk_data_o   (hit_data),
    .lk_seq_o    (hit_seq)
  );

  assign st_ready_o     = !full;
  assign mem_wr_valid_o = !empty;
  assign idle_o         = empty;
  assign ld_fwd_o       = hit;
  assign ld_data_o      = hit ? hit_data : ld_mem_data_i;

  // window edges that coincide with the load's own cycle
  assign cap_open  = !hit || (drain && head_seq == hit_seq);
  assign cap_close = empty || (drain && head_seq == tail_seq);

  sob_pick #(.N(SLOTS)) u_free (
    .req_i (~busy),
    .gnt_o (free_gnt),
    .any_o (ld_ready_o)
  );

  assign ld_acc = ld_valid_i && ld_ready_o;
  assign alloc  = free_gnt & {SLOTS{ld_acc}};

  sob_watch #(.SLOTS(SLOTS), .AW(AW), .DW(DW), .IDW(IDW), .SW(SW)) u_watch (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .alloc_i         (alloc),
    .cap_addr_i      (ld_addr_i),
    .cap_id_i        (ld_id_i),
    .cap_data_i      (ld_data_o),
    .cap_open_seq_i  (hit_seq),
    .cap_close_seq_i (tail_seq),
    .cap_open_i      (cap_open),
    .cap_close_i     (cap_close),
    .drain_i         (drain),
    .drain_seq_i     (head_seq),
    .inv_valid_i     (inv_valid_i),
    .inv_addr_i      (inv_addr_i),
    .release_i       (rpt_gnt),
    .busy_o          (busy),
    .done_o          (done),
    .id_o            (slot_id),
    .data_o          (slot_data),
    .log_o           (slot_log)
  );

  sob_pick #(.N(SLOTS)) u_rpt (
    .req_i (done),
    .gnt_o (rpt_gnt),
    .any_o (rpt_valid_o)
  );

  always_comb begin
    rpt_id_o   = '0;
    rpt_data_o = '0;
    rpt_log_o  = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (rpt_gnt[i]) begin
        rpt_id_o   = slot_id[i];
        rpt_data_o = slot_data[i];
        rpt_log_o  = slot_log[i];
      end
    end
  end
endmodule

// File: rtl/sob_chk.sv
module sob_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          st_ready_o,
  input logic          mem_wr_valid_o,
  input logic          mem_wr_ready_i,
  input logic [AW-1:0] mem_wr_addr_o,
  input logic [DW-1:0] mem_wr_data_o,
  input logic          idle_o,
  input logic          ld_valid_i,
  input logic          ld_ready_o,
  input logic          ld_fwd_o,
  input logic [DW-1:0] ld_data_o,
  input logic [DW-1:0] ld_mem_data_i,
  input logic          rpt_valid_o
);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_valid_o && !mem_wr_ready_i |=>
      mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o));

  p_full_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_ready_o |-> mem_wr_valid_o && !idle_o);

  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o != mem_wr_valid_o);

  p_no_fwd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i && idle_o |-> !ld_fwd_o && ld_data_o == ld_mem_data_i);

  p_empty_rpt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i && ld_ready_o && idle_o |=> rpt_valid_o);
endmodule

bind store_order_buf sob_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .st_ready_o     (st_ready_o),
  .mem_wr_valid_o (mem_wr_valid_o),
  .mem_wr_ready_i (mem_wr_ready_i),
  .mem_wr_addr_o  (mem_wr_addr_o),
  .mem_wr_data_o  (mem_wr_data_o),
  .idle_o         (idle_o),
  .ld_valid_i     (ld_valid_i),
  .ld_ready_o     (ld_ready_o),
  .ld_fwd_o       (ld_fwd_o),
  .ld_data_o      (ld_data_o),
  .ld_mem_data_i  (ld_mem_data_i),
  .rpt_valid_o    (rpt_valid_o)
);

// File: tb/sim_store_order_buf.sv
`timescale 1ns/1ps
module sim_store_order_buf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        st_valid_i = 1'b0, st_ready_o;
  logic [15:0] st_addr_i = '0;
  logic [31:0] st_data_i = '0;
  logic        mem_wr_valid_o, mem_wr_ready_i = 1'b0;
  logic [15:0] mem_wr_addr_o;
  logic [31:0] mem_wr_data_o;
  logic        ld_valid_i = 1'b0, ld_ready_o;
  logic [15:0] ld_addr_i = '0;
  logic [3:0]  ld_id_i = '0;
  logic [31:0] ld_mem_data_i, ld_data_o;
  logic        ld_fwd_o;
  logic        inv_valid_i = 1'b0;
  logic [15:0] inv_addr_i = '0;
  logic        rpt_valid_o, rpt_log_o, idle_o;
  logic [3:0]  rpt_id_o;
  logic [31:0] rpt_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  function automatic logic [31:0] mem_of(input logic [15:0] a);
    return {16'hA5A5, a};
  endfunction
  assign ld_mem_data_i = mem_of(ld_addr_i);

  store_order_buf u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic push(input logic [15:0] a, input logic [31:0] d);
    st_valid_i = 1'b1; st_addr_i = a; st_data_i = d;
    tick();
    st_valid_i = 1'b0;
  endtask

  task automatic expect_rpt(input string tag, input logic [3:0] id, input logic [31:0] d, input bit lg);
    #1;
    check(rpt_valid_o, {tag, " rpt_valid"}, 32'(rpt_valid_o), 32'd1);
    check(rpt_id_o == id, {tag, " rpt_id"}, 32'(rpt_id_o), 32'(id));
    check(rpt_data_o == d, {tag, " rpt_data"}, rpt_data_o, d);
    check(rpt_log_o == lg, {tag, " rpt_log"}, 32'(rpt_log_o), 32'(lg));
    tick();
  endtask

  task automatic t_reset();
    #1;
    check(idle_o && st_ready_o && !mem_wr_valid_o, "R2 reset idle/ready", {29'd0, idle_o, st_ready_o, mem_wr_valid_o}, 32'b110);
    check(!rpt_valid_o && ld_ready_o, "R10 reset slots", {30'd0, rpt_valid_o, ld_ready_o}, 32'b01);
  endtask

  task automatic t_fill_forward();
    mem_wr_ready_i = 1'b0;
    push(16'h0010, 32'h111);
    push(16'h0020, 32'h222);
    push(16'h0010, 32'h333);
    push(16'h0030, 32'h444);
    #1;
    check(!st_ready_o && !idle_o, "R2 full", {30'd0, st_ready_o, idle_o}, 32'd0);
    ld_valid_i = 1'b1; ld_addr_i = 16'h0010; ld_id_i = 4'd1;
    #1;
    check(ld_fwd_o && ld_data_o == 32'h333, "R4 youngest match", ld_data_o, 32'h333);
    tick();
    ld_addr_i = 16'h0050; ld_id_i = 4'd2;
    #1;
    check(!ld_fwd_o && ld_data_o == mem_of(16'h0050), "R3 memory value", ld_data_o, mem_of(16'h0050));
    tick();
    ld_valid_i = 1'b0;
    mem_wr_ready_i = 1'b1;
    #1; check(mem_wr_addr_o == 16'h0010 && mem_wr_data_o == 32'h111, "R1 drain 0", mem_wr_data_o, 32'h111);
    tick();
    #1; check(mem_wr_addr_o == 16'h0020 && mem_wr_data_o == 32'h222, "R1 drain 1", mem_wr_data_o, 32'h222);
    tick();
    #1; check(mem_wr_addr_o == 16'h0010 && mem_wr_data_o == 32'h333, "R1 drain 2", mem_wr_data_o, 32'h333);
    tick();
    mem_wr_ready_i = 1'b0;
    #1; check(mem_wr_addr_o == 16'h0030 && mem_wr_data_o == 32'h444, "R1 drain 3", mem_wr_data_o, 32'h444);
    inv_valid_i = 1'b1; inv_addr_i = 16'h0010;
    tick();
    inv_valid_i = 1'b0;
    mem_wr_ready_i = 1'b1;
    tick();
    mem_wr_ready_i = 1'b0;
    expect_rpt("R7 R9 forwarded load in window", 4'd1, 32'h333, 1'b1);
    expect_rpt("R8 R11 other address second slot", 4'd2, mem_of(16'h0050), 1'b0);
    #1;
    check(!rpt_valid_o && idle_o, "R9 no further report", {30'd0, rpt_valid_o, idle_o}, 32'b01);
  endtask

  task automatic t_early_inv();
    push(16'h0040, 32'h555);
    push(16'h0044, 32'h666);
    ld_valid_i = 1'b1; ld_addr_i = 16'h0040; ld_id_i = 4'd3;
    #1; check(ld_fwd_o && ld_data_o == 32'h555, "R4 single match", ld_data_o, 32'h555);
    tick();
    ld_valid_i = 1'b0;
    inv_valid_i = 1'b1; inv_addr_i = 16'h0040;
    tick();
    inv_valid_i = 1'b0;
    mem_wr_ready_i = 1'b1; tick(); mem_wr_ready_i = 1'b0;
    tick();
    mem_wr_ready_i = 1'b1; tick(); mem_wr_ready_i = 1'b0;
    expect_rpt("R8 invalidation before open", 4'd3, 32'h555, 1'b0);
  endtask

  task automatic t_same_cycle();
    st_valid_i = 1'b1; st_addr_i = 16'h0060; st_data_i = 32'h777;
    ld_valid_i = 1'b1; ld_addr_i = 16'h0060; ld_id_i = 4'd4;
    #1;
    check(!ld_fwd_o && ld_data_o == mem_of(16'h0060), "R5 same-cycle store hidden", ld_data_o, mem_of(16'h0060));
    tick();
    st_valid_i = 1'b0; ld_valid_i = 1'b0;
    expect_rpt("R6 empty buffer load", 4'd4, mem_of(16'h0060), 1'b0);
    mem_wr_ready_i = 1'b1; tick(); mem_wr_ready_i = 1'b0;
  endtask

  task automatic t_close_inclusive();
    push(16'h0070, 32'h888);
    ld_valid_i = 1'b1; ld_addr_i = 16'h0074; ld_id_i = 4'd5;
    tick();
    ld_valid_i = 1'b0;
    mem_wr_ready_i = 1'b1; inv_valid_i = 1'b1; inv_addr_i = 16'h0074;
    tick();
    mem_wr_ready_i = 1'b0; inv_valid_i = 1'b0;
    expect_rpt("R7 invalidation in closing cycle", 4'd5, mem_of(16'h0074), 1'b1);
  endtask

  task automatic t_slots_full();
    push(16'h0080, 32'h999);
    for (int k = 0; k < 4; k++) begin
      ld_valid_i = 1'b1; ld_addr_i = 16'h0090 + 16'(k); ld_id_i = 4'(6 + k);
      tick();
    end
    ld_valid_i = 1'b0;
    #1; check(!ld_ready_o, "R10 slots exhausted", 32'(ld_ready_o), 32'd0);
    mem_wr_ready_i = 1'b1; tick(); mem_wr_ready_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      expect_rpt("R11 report order", 4'(6 + k), mem_of(16'h0090 + 16'(k)), 1'b0);
    end
    #1; check(ld_ready_o && idle_o, "R10 slots free again", {30'd0, ld_ready_o, idle_o}, 32'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fill_forward();
    t_early_inv();
    t_same_cycle();
    t_close_inclusive();
    t_slots_full();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule